// File: doc/BRIEF.md
# Addressable One-Bit Register Bank

This block holds a small bank of one-bit storage registers that all share a single one-bit data bus. A source address selects the register that drives the bus. A destination address selects the register that a command acts on. The write command copies the current bus value into the destination register. The set command forces the destination register to 1. The bus is built as a one-hot AND-OR multiplexer, so exactly one register always drives it and it never floats.

Three address decoders produce the select lines: one for the bus driver, one for write enables and one for set enables. Every register is also brought out on a parallel vector so that indicators can show it. The global reset clears the whole bank at once and wins over any command. Commands take effect at the rising clock edge.

Top module: `bitbank_top`

## Requirements
- R1: While `rst_n` is low, every bit of `regs_o` is 0, and it stays 0 at the first edge after release when no command is given.
- R2: `bus_o` always equals bit `src_addr` of `regs_o`, for every source address. Register i is bit i of `regs_o`.
- R3: With `wr_i` high and `set_i` low, at the rising edge register `dst_addr` takes the value `bus_o` had before that edge.
- R4: With `set_i` high, at the rising edge register `dst_addr` becomes 1 whatever the bus value is.
- R5: When `set_i` and `wr_i` are both high, set wins and the destination register becomes 1.
- R6: A write or set changes no register other than the one at `dst_addr`.
- R7: With `wr_i` and `set_i` both low, no register changes at the edge.
- R8: A write whose source and destination are the same register leaves the bank unchanged.
- R9: Asserting `rst_n` low clears the bank even while `wr_i` or `set_i` is high. Reset has priority over set and over write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands act on its rising edge |
| rst_n | input | 1 | Global clear, active low, asynchronous by default |
| src_addr | input | ADDR_W (2) | Register that drives the bus |
| dst_addr | input | ADDR_W (2) | Register that a write or set acts on |
| wr_i | input | 1 | Copy the bus value into the destination register |
| set_i | input | 1 | Force the destination register to 1 |
| bus_o | output | 1 | Current shared bus value |
| regs_o | output | NUM_REGS (4) | Contents of all registers, bit i is register i |

## Verification
The bench sweeps every one of the 16 starting bank contents against every source and destination pair and every combination of the two commands. A write with differing bus and destination values shows that the bus value is copied and not a constant. Loading the source with a 0 before a set shows that set ignores the bus. The both-commands case shows the priority between set and write. Comparing the full vector after each operation catches a decoder that enables the wrong register or more than one register. Pairs where source and destination are equal cover the self-copy case. A reset pulse applied while commands are held shows that reset has priority over both commands.

// File: rtl/bitbank_pkg.sv
package bitbank_pkg;
   function automatic int unsigned clog2_min1(input int unsigned n);
      int unsigned w;
      w = 0;
      while ((1 << w) < n) w++;
      return (w == 0) ? 1 : w;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/bitbank_dec.sv
module bitbank_dec #(
   parameter int unsigned NUM_OUT = 4,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_OUT-1:0] onehot
);
   initial begin
      assert ((1 << ADDR_W) >= NUM_OUT)
         else $error("bitbank_dec: ADDR_W too narrow for NUM_OUT");
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
      assign onehot[i] = en && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/bitbank_mux.sv
module bitbank_mux #(
   parameter int unsigned NUM_IN = 4
) (
   input  logic [NUM_IN-1:0] sel_onehot,
   input  logic [NUM_IN-1:0] data,
   output logic              bus
);
   logic [NUM_IN-1:0] gated;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_and
      assign gated[i] = sel_onehot[i] & data[i];
   end

   assign bus = |gated;
endmodule

// File: rtl/bitbank_cell.sv
module bitbank_cell #(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic set_en,
   input  logic d,
   output logic q
);
   logic q_next;

   always_comb begin
      q_next = q;
      if (set_en)     q_next = 1'b1;
      else if (wr_en) q_next = d;
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= q_next;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= q_next;
      end
   end

   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && wr_en) |=> q);

   assert_set_forces_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> q);

   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !wr_en) |=> $stable(q));
endmodule

// File: rtl/bitbank_top.sv
module bitbank_top
   import bitbank_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 4,
   parameter bit          ASYNC_RST = 1'b1,
   localparam int unsigned ADDR_W   = clog2_min1(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   src_addr,
   input  logic [ADDR_W-1:0]   dst_addr,
   input  logic                wr_i,
   input  logic                set_i,
   output logic                bus_o,
   output logic [NUM_REGS-1:0] regs_o
);
   initial begin
      assert (is_pow2(NUM_REGS) && NUM_REGS >= 2)
         else $error("bitbank_top: NUM_REGS must be a power of two, at least 2");
   end

   logic [NUM_REGS-1:0] drive_sel;
   logic [NUM_REGS-1:0] wr_sel;
   logic [NUM_REGS-1:0] set_sel;
   logic [NUM_REGS-1:0] q;

   bitbank_dec #(.NUM_OUT(NUM_REGS), .ADDR_W(ADDR_W)) u_dec_drive (
      .en(1'b1), .addr(src_addr), .onehot(drive_sel)
   );
   bitbank_dec #(.NUM_OUT(NUM_REGS), .ADDR_W(ADDR_W)) u_dec_wr (
      .en(wr_i), .addr(dst_addr), .onehot(wr_sel)
   );
   bitbank_dec #(.NUM_OUT(NUM_REGS), .ADDR_W(ADDR_W)) u_dec_set (
      .en(set_i), .addr(dst_addr), .onehot(set_sel)
   );

   bitbank_mux #(.NUM_IN(NUM_REGS)) u_bus (
      .sel_onehot(drive_sel), .data(q), .bus(bus_o)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      bitbank_cell #(.ASYNC_RST(ASYNC_RST)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_sel[i]), .set_en(set_sel[i]),
         .d(bus_o), .q(q[i])
      );
   end

   assign regs_o = q;

   assert_one_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(drive_sel) && (bus_o == regs_o[src_addr]));

   assert_write_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !set_i) |=> (regs_o[$past(dst_addr)] == $past(bus_o)));

   assert_only_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i || set_i) |=>
         (((regs_o ^ $past(regs_o)) & ~(NUM_REGS'(1) << $past(dst_addr))) == '0));

   assert_self_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !set_i && (src_addr == dst_addr)) |=> $stable(regs_o));

   assert_cmd_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel) && $onehot0(set_sel));
endmodule

// File: tb/bitbank_top_tb_top.sv
module bitbank_top_tb_top;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_addr = '0;
   logic [1:0] dst_addr = '0;
   logic       wr_i = 1'b0;
   logic       set_i = 1'b0;
   logic       bus_o;
   logic [N-1:0] regs_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bitbank_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .dst_addr(dst_addr),
      .wr_i(wr_i), .set_i(set_i), .bus_o(bus_o), .regs_o(regs_o)
   );

   task automatic check_vec(input string req, input logic [N-1:0] act,
                            input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: regs actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: bus actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_i = 1'b0; set_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input logic [1:0] s, input logic [1:0] d,
                       input logic w, input logic st);
      src_addr = s; dst_addr = d; wr_i = w; set_i = st;
      @(negedge clk);
      wr_i = 1'b0; set_i = 1'b0;
   endtask

   task automatic load(input logic [N-1:0] pat);
      do_reset();
      for (int i = 0; i < N; i++)
         if (pat[i]) step(2'(0), 2'(i), 1'b0, 1'b1);
   endtask

   initial begin
      #1;
      check_vec("R1", regs_o, '0);
      do_reset();
      step(2'd0, 2'd0, 1'b0, 1'b0);
      check_vec("R1", regs_o, '0);

      for (int pat = 0; pat < 16; pat++) begin
         for (int op = 0; op < 4; op++) begin
            for (int s = 0; s < N; s++) begin
               for (int d = 0; d < N; d++) begin
                  logic [N-1:0] p;
                  logic [N-1:0] exp;
                  logic w;
                  logic st;
                  string req;
                  p = 4'(pat);
                  w = op[0];
                  st = op[1];
                  load(p);
                  src_addr = 2'(s);
                  #1;
                  check_bit("R2", bus_o, p[s]);
                  exp = p;
                  if (st) begin
                     exp[d] = 1'b1;
                     req = w ? "R5" : "R4";
                  end else if (w) begin
                     exp[d] = p[s];
                     req = (s == d) ? "R8" : "R3";
                  end else begin
                     req = "R7";
                  end
                  step(2'(s), 2'(d), w, st);
                  check_vec(req, regs_o, exp);
                  if ((w || st) && d != s) begin
                     logic [N-1:0] m;
                     m = ~(4'b0001 << d);
                     check_vec("R6", regs_o & m, p & m);
                  end
               end
            end
         end
      end

      // R9: reset while commands are held
      load(4'b1010);
      src_addr = 2'd1; dst_addr = 2'd2; wr_i = 1'b1; set_i = 1'b1;
      #2;
      rst_n = 1'b0;
      #1;
      check_vec("R9", regs_o, '0);
      @(negedge clk);
      check_vec("R9", regs_o, '0);
      wr_i = 1'b0; set_i = 1'b0;
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule